// File: doc/BRIEF.md
# Two-level carry-lookahead adder

This block adds two 16-bit unsigned operands and a carry-in in pure combinational logic. Each operand bit pair first yields a generate term (both bits set) and a propagate term (either bit set). Four 4-bit groups combine those terms into a group generate and a group propagate. A second lookahead level uses only the four group pairs and the carry-in to form every carry entering a group boundary, including the final carry-out, so no carry ripples from one group to the next.

Inside a group, each bit's incoming carry comes from a lookahead expression over the group's own terms and the group's incoming carry. Each sum bit is the exclusive-OR of the two operand bits and that incoming carry. The inclusive-OR propagate is enough to move carries, but it cannot form the sum. The block also exports the whole-word generate and propagate, so a wider adder can place this block under a further lookahead level.

Top module: `cla16_two_level`

## Requirements
- R1: For every a, b and cin, the 17-bit value {cout_o, sum_o} equals a + b + cin.
- R2: grp_gen_o is 1 exactly when a + b, without the carry-in, is 2^16 or more.
- R3: grp_prop_o is 1 exactly when every bit position has at least one operand bit set, that is, when (a | b) is all ones.
- R4: grp_gen_o and grp_prop_o do not depend on cin_i. For the same a and b, they have the same values with cin_i = 0 and with cin_i = 1.
- R5: cout_o equals grp_gen_o OR (grp_prop_o AND cin_i).
- R6: The carry into bit 4, bit 8 and bit 12 is the overflow of the low 4, 8 and 12 bits of a + b + cin. At the ports it shows as sum_o[i] XOR a[i] XOR b[i] for i = 4, 8, 12.
- R7: Corner operands give exact results. 0 + 0 + 0 gives sum 0, cout 0 and both group outputs 0. 0xFFFF + 0 + 1 gives sum 0 and cout 1. 0xFFFF + 0x0001 + 0 gives sum 0 and cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 1 | Whole-word generate, independent of carry-in |
| grp_prop_o | output | 1 | Whole-word propagate, independent of carry-in |

## Verification
The block has no state, so any fault in a group term or a boundary carry shows at the ports as soon as the inputs settle. The symptom is a wrong sum, usually the single bit at a group boundary flipped together with the bits above it. A carry fault is masked unless a carry actually has to cross that boundary. For that reason the stimulus includes all-ones words, long carry chains started by the carry-in, and alternating patterns in which propagate is set everywhere while generate is clear. Because the bench recovers each boundary carry from sum_o, a fault in one group's carry is caught at that group.

// File: rtl/cla16_two_level.sv
module cla16_two_level (
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic        cin_i,
  output logic [15:0] sum_o,
  output logic        cout_o,
  output logic        grp_gen_o,
  output logic        grp_prop_o
);
  localparam int GW = 4;
  localparam int NG = 16 / GW;

  logic [15:0]   g, p, bc;
  logic [NG-1:0] gg, gp, gco;
  logic [NG:0]   gc;

  assign g = a_i & b_i;
  assign p = a_i | b_i;

  for (genvar k = 0; k < NG; k++) begin : grp
    localparam int B = k * GW;

    assign gg[k] = g[B+3] | (g[B+2] & p[B+3]) | (g[B+1] & p[B+2] & p[B+3])
                 | (g[B] & p[B+1] & p[B+2] & p[B+3]);
    assign gp[k] = &p[B+3:B];

    assign bc[B]   = gc[k];
    assign bc[B+1] = g[B] | (p[B] & gc[k]);
    assign bc[B+2] = g[B+1] | (p[B+1] & g[B]) | (p[B+1] & p[B] & gc[k]);
    assign bc[B+3] = g[B+2] | (p[B+2] & g[B+1]) | (p[B+2] & p[B+1] & g[B])
                   | (p[B+2] & p[B+1] & p[B] & gc[k]);
    assign gco[k]  = g[B+3] | (p[B+3] & g[B+2]) | (p[B+3] & p[B+2] & g[B+1])
                   | (p[B+3] & p[B+2] & p[B+1] & g[B])
                   | (p[B+3] & p[B+2] & p[B+1] & p[B] & gc[k]);

    always_comb begin
      assert_group_carry_agree_R6: assert (gco[k] == gc[k+1])
        else $error("group %0d local carry disagrees with second level", k);
      assert_gen_forces_carry_R2: assert (!gg[k] || gc[k+1])
        else $error("group %0d generates but no carry leaves it", k);
      assert_no_prop_blocks_cin_R4: assert (gp[k] || (gc[k+1] == gg[k]))
        else $error("group %0d without propagate passed its carry-in", k);
    end
  end

  assign gc[0] = cin_i;
  assign gc[1] = gg[0] | (gp[0] & cin_i);
  assign gc[2] = gg[1] | (gp[1] & gg[0]) | (gp[1] & gp[0] & cin_i);
  assign gc[3] = gg[2] | (gp[2] & gg[1]) | (gp[2] & gp[1] & gg[0])
               | (gp[2] & gp[1] & gp[0] & cin_i);
  assign gc[4] = gg[3] | (gp[3] & gg[2]) | (gp[3] & gp[2] & gg[1])
               | (gp[3] & gp[2] & gp[1] & gg[0])
               | (gp[3] & gp[2] & gp[1] & gp[0] & cin_i);

  assign sum_o      = a_i ^ b_i ^ bc;
  assign cout_o     = gc[NG];
  assign grp_gen_o  = gg[3] | (gp[3] & gg[2]) | (gp[3] & gp[2] & gg[1])
                    | (gp[3] & gp[2] & gp[1] & gg[0]);
  assign grp_prop_o = &gp;

  always_comb begin
    assert_sum_matches_R1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {16'b0, cin_i}))
      else $error("sum mismatch");
    assert_cout_form_R5: assert (cout_o == (grp_gen_o | (grp_prop_o & cin_i)))
      else $error("carry-out not formed from word terms");
    assert_prop_all_or_R3: assert (grp_prop_o == (&(a_i | b_i)))
      else $error("word propagate mismatch");
  end
endmodule

// File: tb/test_cla16_two_level.sv
module test_cla16_two_level;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout, ggo, gpo;

  cla16_two_level i_cla16_two_level (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .grp_gen_o(ggo), .grp_prop_o(gpo)
  );

  typedef struct {
    logic [15:0] a, b;
    logic        cin;
    logic [16:0] full;
    logic        gg, gp;
    logic [2:0]  bnd;
  } item_t;

  item_t sbq[$];
  int total = 0, bad = 0;
  bit drv_done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%0b actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] x, logic [15:0] y, logic c);
    item_t it;
    logic [16:0] lo;
    @(posedge clk);
    #1;
    a = x; b = y; cin = c;
    it.a = x; it.b = y; it.cin = c;
    it.full = {1'b0, x} + {1'b0, y} + {16'b0, c};
    lo = {1'b0, x} + {1'b0, y};
    it.gg = lo[16];
    it.gp = &(x | y);
    for (int k = 1; k < 4; k++) begin
      logic [16:0] m;
      m = ({1'b0, x} & ((17'd1 << (4*k)) - 1)) + ({1'b0, y} & ((17'd1 << (4*k)) - 1)) + {16'b0, c};
      it.bnd[k-1] = m[4*k];
    end
    sbq.push_back(it);
  endtask

  task automatic both(logic [15:0] x, logic [15:0] y);
    drive(x, y, 1'b0);
    drive(x, y, 1'b1);
  endtask

  always @(negedge clk) begin
    if (!rst && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      chk({cout, sum} == it.full, "R1", {15'b0, cout, sum}, {15'b0, it.full});
      chk(ggo == it.gg, "R2", {31'b0, ggo}, {31'b0, it.gg});
      chk(gpo == it.gp, "R3", {31'b0, gpo}, {31'b0, it.gp});
      chk(cout == (it.gg | (it.gp & it.cin)), "R5", {31'b0, cout}, {31'b0, it.gg | (it.gp & it.cin)});
      for (int k = 1; k < 4; k++) begin
        logic obs;
        obs = sum[4*k] ^ it.a[4*k] ^ it.b[4*k];
        chk(obs == it.bnd[k-1], "R6", {31'b0, obs}, {31'b0, it.bnd[k-1]});
      end
    end
  end

  logic prev_gg, prev_gp;
  task automatic cin_indep(logic [15:0] x, logic [15:0] y);
    @(posedge clk); #1; a = x; b = y; cin = 1'b0;
    #3; prev_gg = ggo; prev_gp = gpo;
    cin = 1'b1;
    #1;
    chk(ggo == prev_gg, "R4", {31'b0, ggo}, {31'b0, prev_gg});
    chk(gpo == prev_gp, "R4", {31'b0, gpo}, {31'b0, prev_gp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3;
    chk(sum == 16'h0 && cout == 1'b0 && ggo == 1'b0 && gpo == 1'b0, "R7 zero",
        {13'b0, ggo, gpo, cout, sum}, 32'h0);
    rst = 1'b0;

    cin_indep(16'hFFFF, 16'h0000);
    cin_indep(16'h8000, 16'h8000);
    cin_indep(16'h1234, 16'h0F0F);
    cin_indep(16'hAAAA, 16'h5555);

    drive(16'h0000, 16'h0000, 1'b0);
    drive(16'hFFFF, 16'h0000, 1'b1);
    drive(16'hFFFF, 16'h0001, 1'b0);
    drive(16'hFFFF, 16'hFFFF, 1'b1);
    both(16'hAAAA, 16'h5555);
    both(16'h5555, 16'h5555);
    both(16'hAAAA, 16'hAAAA);
    both(16'h8000, 16'h8000);
    both(16'h000F, 16'h0001);
    both(16'h0FFF, 16'h0001);
    both(16'h00FF, 16'hFF00);
    for (int i = 0; i < 3000; i++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom));
    end
    repeat (3) @(posedge clk);
    drv_done = 1;
  end

  initial begin
    fork
      wait (drv_done);
      begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule